// File: doc/BRIEF.md
# Wake-State Clock Source Selector

This block picks the clock source for a processor clock domain from a single 32-bit policy register. The top four register bits are a wake-state word. They are priority-decoded into one of five operating states. Each state owns a 4-bit source field in the low part of the register. The field that belongs to the decoded state drives a registered source index and a one-hot select vector. A downstream glitch-free clock switch consumes these outputs.

Software can rewrite the whole register through the write port. It can also issue a source request, which rewrites only the field of the active state. In the half-rate variant, the PLL input is also offered at a virtual index. A request for that index selects the PLL and clears a bypass bit, and the block then raises a divide-by-two enable. The clock generators, the divider and the switching itself live outside the block.

Top module: `wake_clk_sel`

## Requirements
- R1: After reset the register reads 0x2000_0000. The outputs then show state RUN (code 2), source index 0, one-hot bit 0 set, and no flags.
- R2: A register write is visible on the read port in the cycle after the write edge, bit for bit equal to the written word.
- R3: The state is decoded from bits 31:28 with strict priority. Bit 31 gives FIQ (code 4), bit 30 gives IRQ (3), bit 29 gives RUN (2), bit 28 gives IDLE (1), and none set gives STANDBY (0). A higher set bit overrides every lower one.
- R4: The active field sits at bits 4*code+3 : 4*code. Its value appears on the index output, with the matching bit set in the 16-bit one-hot output. All outputs follow a register change one clock later.
- R5: A field value at or above the populated count (9 by default) drives index 0 and raises the invalid-source flag.
- R6: The divide-by-two enable is high exactly when the selected field is 8 and bit 16 is clear.
- R7: The state-error flag is high whenever the decoded state is neither RUN nor IDLE.
- R8: A source request with an index below 9, made in RUN or IDLE, writes that index into the active field and leaves all other fields unchanged. An index of 8 also sets bit 16.
- R9: A source request for virtual index 16 writes 8 into the active field and clears bit 16.
- R10: A source request leaves the register unchanged in either of two cases: the state is not RUN or IDLE, or the index is neither populated (below 9) nor 16.
- R11: When a register write and a source request arrive in the same cycle, the write is taken and the request is dropped.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Full register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read-back |
| req_valid_i | input | 1 | Source request strobe |
| req_idx_i | input | 5 | Requested source index (16 = half-rate PLL) |
| sel_idx_o | output | 4 | Selected source index |
| sel_oh_o | output | 16 | One-hot source select |
| half_en_o | output | 1 | Divide-by-two enable for the PLL source |
| state_o | output | 3 | Decoded wake state code |
| state_err_o | output | 1 | State is not RUN or IDLE |
| bad_src_o | output | 1 | Active field names an unpopulated source |

## Verification
A full register write and a field-level source request can both be present on the same edge, and they compete for the same register. The bench drives both strobes in one cycle with differing contents. It then judges the read-back and the select outputs against a model in which the write alone took effect. It also applies requests in non-run states and with out-of-range indices, and confirms through the read port that the register did not move.

// File: rtl/wake_clk_pkg.sv
package wake_clk_pkg;
  localparam int FW = 4;
  localparam int NSEL = 1 << FW;
  localparam logic [31:0] RST_POLICY = 32'h2000_0000;

  typedef enum logic [2:0] {
    ST_STBY = 3'd0,
    ST_IDLE = 3'd1,
    ST_RUN  = 3'd2,
    ST_IRQ  = 3'd3,
    ST_FIQ  = 3'd4
  } wake_st_e;
endpackage

// File: rtl/wake_state_prio.sv
module wake_state_prio
  import wake_clk_pkg::*;
(
  input  logic [3:0] wake_i,
  output wake_st_e   state_o,
  output logic       run_ok_o
);
  always_comb begin
    if (wake_i[3])      state_o = ST_FIQ;
    else if (wake_i[2]) state_o = ST_IRQ;
    else if (wake_i[1]) state_o = ST_RUN;
    else if (wake_i[0]) state_o = ST_IDLE;
    else                state_o = ST_STBY;
  end

  assign run_ok_o = (state_o == ST_RUN) || (state_o == ST_IDLE);

  always_comb begin
    assert_stby_only_zero_R3: assert ((state_o != ST_STBY) || (wake_i == 4'b0000));
  end
endmodule

// File: rtl/wake_policy_reg.sv
module wake_policy_reg
  import wake_clk_pkg::*;
#(
  parameter int NUM_SRC   = 9,
  parameter bit HAS_HALF  = 1'b1,
  parameter int PLL_IDX   = 8,
  parameter int ALIAS_IDX = 16,
  parameter int BYP_BIT   = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [31:0]   wr_data_i,
  input  logic          req_valid_i,
  input  logic [FW:0]   req_idx_i,
  input  wake_st_e      state_i,
  input  logic          run_ok_i,
  output logic [31:0]   policy_o
);
  localparam logic [FW:0] NSRC_W  = (FW+1)'(NUM_SRC);
  localparam logic [FW:0] PLL_W   = (FW+1)'(PLL_IDX);
  localparam logic [FW:0] ALIAS_W = (FW+1)'(ALIAS_IDX);

  logic [31:0] pol_q, pol_d;
  logic [4:0]  off;
  logic        is_alias, idx_ok, req_take;

  assign off      = {state_i, 2'b00};
  assign is_alias = HAS_HALF && (req_idx_i == ALIAS_W);
  assign idx_ok   = (req_idx_i < NSRC_W) || is_alias;
  assign req_take = req_valid_i && !wr_en_i && run_ok_i && idx_ok;

  always_comb begin
    pol_d = pol_q;
    if (wr_en_i) begin
      pol_d = wr_data_i;
    end else if (req_take) begin
      if (is_alias) begin
        pol_d[off +: FW] = PLL_W[FW-1:0];
        pol_d[BYP_BIT]   = 1'b0;
      end else begin
        pol_d[off +: FW] = req_idx_i[FW-1:0];
        if (HAS_HALF && req_idx_i == PLL_W) pol_d[BYP_BIT] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pol_q <= RST_POLICY;
    else         pol_q <= pol_d;
  end

  assign policy_o = pol_q;

  assert_wr_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (pol_q == $past(wr_data_i)));
  assert_req_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && (!run_ok_i || !idx_ok)) |=> $stable(pol_q));
  assert_alias_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !wr_en_i && run_ok_i && is_alias) |=> !pol_q[BYP_BIT]);
endmodule

// File: rtl/wake_src_map.sv
module wake_src_map
  import wake_clk_pkg::*;
#(
  parameter int NUM_SRC  = 9,
  parameter bit HAS_HALF = 1'b1,
  parameter int PLL_IDX  = 8
) (
  input  logic [19:0]   fields_i,
  input  logic          byp_i,
  input  wake_st_e      state_i,
  output logic [FW-1:0] idx_o,
  output logic [NSEL-1:0] oh_o,
  output logic          half_o,
  output logic          bad_o
);
  localparam logic [FW:0] NSRC_W = (FW+1)'(NUM_SRC);
  localparam logic [FW-1:0] PLL_W = FW'(PLL_IDX);

  logic [4:0]    off;
  logic [FW-1:0] field;

  assign off    = {state_i, 2'b00};
  assign field  = fields_i[off +: FW];
  assign bad_o  = {1'b0, field} >= NSRC_W;
  assign idx_o  = bad_o ? '0 : field;
  assign oh_o   = NSEL'(1) << idx_o;
  assign half_o = HAS_HALF && !bad_o && (field == PLL_W) && !byp_i;
endmodule

// File: rtl/wake_clk_sel.sv
module wake_clk_sel
  import wake_clk_pkg::*;
#(
  parameter int NUM_SRC   = 9,
  parameter bit HAS_HALF  = 1'b1,
  parameter int PLL_IDX   = 8,
  parameter int ALIAS_IDX = 16,
  parameter int BYP_BIT   = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  input  logic        req_valid_i,
  input  logic [4:0]  req_idx_i,
  output logic [3:0]  sel_idx_o,
  output logic [15:0] sel_oh_o,
  output logic        half_en_o,
  output logic [2:0]  state_o,
  output logic        state_err_o,
  output logic        bad_src_o
);
  logic [31:0]     policy;
  wake_st_e        st;
  logic            run_ok;
  logic [FW-1:0]   m_idx;
  logic [NSEL-1:0] m_oh;
  logic            m_half, m_bad;

  wake_state_prio u_prio (
    .wake_i   (policy[31:28]),
    .state_o  (st),
    .run_ok_o (run_ok)
  );

  wake_policy_reg #(
    .NUM_SRC(NUM_SRC), .HAS_HALF(HAS_HALF), .PLL_IDX(PLL_IDX),
    .ALIAS_IDX(ALIAS_IDX), .BYP_BIT(BYP_BIT)
  ) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .req_valid_i (req_valid_i),
    .req_idx_i   (req_idx_i),
    .state_i     (st),
    .run_ok_i    (run_ok),
    .policy_o    (policy)
  );

  wake_src_map #(
    .NUM_SRC(NUM_SRC), .HAS_HALF(HAS_HALF), .PLL_IDX(PLL_IDX)
  ) u_map (
    .fields_i (policy[19:0]),
    .byp_i    (policy[BYP_BIT]),
    .state_i  (st),
    .idx_o    (m_idx),
    .oh_o     (m_oh),
    .half_o   (m_half),
    .bad_o    (m_bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_idx_o   <= '0;
      sel_oh_o    <= 16'h0001;
      half_en_o   <= 1'b0;
      state_o     <= ST_RUN;
      state_err_o <= 1'b0;
      bad_src_o   <= 1'b0;
    end else begin
      sel_idx_o   <= m_idx;
      sel_oh_o    <= m_oh;
      half_en_o   <= m_half;
      state_o     <= st;
      state_err_o <= !run_ok;
      bad_src_o   <= m_bad;
    end
  end

  assign rd_data_o = policy;

  assert_fiq_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_FIQ) |-> $past(policy[31]));
  assert_half_pll_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_en_o |-> (sel_idx_o == 4'(PLL_IDX)) && !bad_src_o);
  assert_err_state_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_err_o |-> (state_o != ST_RUN) && (state_o != ST_IDLE));
  assert_bad_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_src_o |-> (sel_idx_o == 4'd0) && (sel_oh_o == 16'h0001));
endmodule

// File: tb/test_wake_clk_sel.sv
`timescale 1ns/1ps
module test_wake_clk_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        req_v = 1'b0;
  logic [4:0]  req_idx = '0;
  logic [31:0] rd_data;
  logic [3:0]  sel_idx;
  logic [15:0] sel_oh;
  logic        half_en, st_err, bad_src;
  logic [2:0]  state;

  int n_chk = 0, n_fail = 0;
  logic [31:0] model = 32'h2000_0000;

  typedef struct {
    string       req;
    logic [31:0] rd;
    logic [3:0]  idx;
    logic [2:0]  st;
    logic        half, bad, err;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  wake_clk_sel i_wake_clk_sel (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .req_valid_i(req_v), .req_idx_i(req_idx),
    .sel_idx_o(sel_idx), .sel_oh_o(sel_oh), .half_en_o(half_en),
    .state_o(state), .state_err_o(st_err), .bad_src_o(bad_src)
  );

  function automatic logic [2:0] st_of(logic [31:0] r);
    if (r[31]) return 3'd4;
    if (r[30]) return 3'd3;
    if (r[29]) return 3'd2;
    if (r[28]) return 3'd1;
    return 3'd0;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic op(string req, bit wr, logic [31:0] wd, bit rq, logic [4:0] ri);
    logic [31:0] n;
    logic [2:0]  s;
    logic [3:0]  f;
    exp_t e;
    n = model;
    s = st_of(model);
    if (wr) n = wd;
    else if (rq && (s == 3'd1 || s == 3'd2) && (ri < 5'd9 || ri == 5'd16)) begin
      if (ri == 5'd16) begin n[s*4 +: 4] = 4'd8; n[16] = 1'b0; end
      else begin n[s*4 +: 4] = ri[3:0]; if (ri == 5'd8) n[16] = 1'b1; end
    end
    model = n;
    @(negedge clk);
    wr_en = wr; wr_data = wd; req_v = rq; req_idx = ri;
    @(negedge clk);
    wr_en = 1'b0; req_v = 1'b0;
    @(posedge clk);
    s = st_of(n);
    f = n[s*4 +: 4];
    e.req = req; e.rd = n; e.st = s;
    e.bad = (f >= 4'd9);
    e.idx = e.bad ? 4'd0 : f;
    e.half = !e.bad && f == 4'd8 && !n[16];
    e.err = !(s == 3'd1 || s == 3'd2);
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.req, "rd_data", rd_data, e.rd);
      chk(e.req, "sel_idx", 32'(sel_idx), 32'(e.idx));
      chk(e.req, "sel_oh", 32'(sel_oh), 32'(16'h1 << e.idx));
      chk(e.req, "state", 32'(state), 32'(e.st));
      chk(e.req, "half_en", 32'(half_en), 32'(e.half));
      chk(e.req, "bad_src", 32'(bad_src), 32'(e.bad));
      chk(e.req, "state_err", 32'(st_err), 32'(e.err));
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rd_data", rd_data, 32'h2000_0000);
    chk("R1", "sel_idx", 32'(sel_idx), 0);
    chk("R1", "sel_oh", 32'(sel_oh), 1);
    chk("R1", "state", 32'(state), 2);
    chk("R1", "flags", {29'd0, half_en, bad_src, st_err}, 0);
    // R2 R4 plain writes
    op("R2", 1, 32'h2000_0500, 0, 0);
    op("R4", 1, 32'h1000_0070, 0, 0);
    // R3 priority, R7 error states
    op("R3", 1, 32'hF000_0000, 0, 0);
    op("R3", 1, 32'h7000_3000, 0, 0);
    op("R3", 1, 32'h3000_0200, 0, 0);
    op("R7", 1, 32'h0000_0004, 0, 0);
    // R5 unpopulated source
    op("R5", 1, 32'h2000_0C00, 0, 0);
    // R6 half-rate enable
    op("R6", 1, 32'h2000_0800, 0, 0);
    op("R6", 1, 32'h2001_0800, 0, 0);
    // R8 R9 requests
    op("R8", 1, 32'h2000_0000, 0, 0);
    op("R8", 0, 0, 1, 5'd3);
    op("R8", 0, 0, 1, 5'd8);
    op("R9", 0, 0, 1, 5'd16);
    op("R8", 1, 32'h1000_0000, 0, 0);
    op("R8", 0, 0, 1, 5'd6);
    // R10 dropped requests
    op("R10", 1, 32'h4000_0000, 0, 0);
    op("R10", 0, 0, 1, 5'd5);
    op("R10", 1, 32'h2000_0000, 0, 0);
    op("R10", 0, 0, 1, 5'd12);
    op("R10", 0, 0, 1, 5'd20);
    // R11 collision
    op("R11", 1, 32'h2000_0100, 1, 5'd5);
    op("R11", 1, 32'h2001_0000, 1, 5'd16);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #50000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule